// File: doc/BRIEF.md
# Indexed Half-Word Load/Store Unit

This unit carries out the memory-access step of an indexed load or store on an 18-bit machine. Each word holds two 9-bit halves: x in bits 8:0 and y in bits 17:9. The address arithmetic is done upstream, so the unit receives an already computed ALU result. It also receives a 3-bit memory opcode, a 2-bit mask mode, and the current value of the target register. From these it forms the memory address, runs one or more whole-word memory cycles on a shared bidirectional data bus, and for loads returns the new target register value on a write-back port.

The mask mode changes only how the address is formed. Transfers never use byte lanes. A half-word load merges the selected 9 bits of the memory word into the old target value. A half-word store is done as read-modify-write: the unit reads the word, replaces the selected half, and writes the whole word back.

The controller is a single state machine:

| State | What happens |
|-------|--------------|
| IDLE | Waits for `start`. |
| ADDR | The address register is loaded and driven. |
| READ | Read strobe is asserted and the memory word is captured. |
| MODIFY | The selected half is spliced into the captured word. |
| WRITE | Write strobe is asserted and the data bus is driven. |
| RECOVER | Address is held, both strobes are low. |
| FINISH | `done` is asserted; `wb_en` is also asserted for loads. |

The transitions are:

| From | To | Condition |
|------|----|-----------|
| IDLE | ADDR | `start` with a valid opcode ("issue") |
| ADDR | READ | a load or a half store |
| ADDR | WRITE | a word store |
| READ | RECOVER | a load |
| READ | MODIFY | a half store |
| MODIFY | WRITE | always |
| WRITE | RECOVER | always |
| RECOVER | FINISH | always |
| FINISH | IDLE | always ("retire") |

Top module: `vec_ldst_unit`

## Requirements
- R1: Mask mode encoding is 00 scalar, 01 x, 10 y, 11 vector. The memory address equals `alu_result` in scalar and vector modes. In x mode address bits 17:9 are zero. In y mode address bits 8:0 are zero.
- R2: A word load (opcode 001) returns the full memory word on `wb_data` in every mask mode.
- R3: An x-half load (opcode 010) returns memory bits 8:0 with `target_val` bits 17:9. A y-half load (opcode 011) returns memory bits 17:9 with `target_val` bits 8:0.
- R4: A word store (opcode 100) writes `target_val` to memory in a single write cycle, with no read strobe.
- R5: An x-half store (opcode 101) or a y-half store (opcode 110) performs one read and then one write to the same address. The written word holds the selected half from `target_val` and the other half unchanged from memory.
- R6: `addr_oe` is high exactly while a memory cycle is in progress, from ADDR through RECOVER. When it is low, `mem_addr` is in high impedance. Every read or write strobe occurs with `addr_oe` high.
- R7: Counting the cycle in which `start` is accepted as cycle 1, `done` rises in cycle 5 for loads and word stores, and in cycle 7 for half stores. `busy` is high from cycle 2 up to and including the `done` cycle.
- R8: `done` is a single-cycle pulse. `wb_en` is asserted only together with `done`, and only for loads.
- R9: A `start` with opcode 000 or 111 is ignored: no busy, no strobes, no `done`.
- R10: A `start` while `busy` is high is ignored and produces no extra memory cycle or write-back.
- R11: After reset the unit is idle, with `busy`, `done`, `wb_en`, both strobes and `addr_oe` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Issue request, sampled in IDLE |
| opcode | input | 3 | Memory opcode (001..110) |
| mask_mode | input | 2 | Address mask mode |
| alu_result | input | 18 | Precomputed address before masking |
| target_val | input | 18 | Current target register value |
| mem_addr | output | 18 | Memory address, high impedance when idle |
| addr_oe | output | 1 | Address bus is being driven |
| mem_data | inout | 18 | Bidirectional memory data bus |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| wb_en | output | 1 | Register write-back enable |
| wb_data | output | 18 | Register write-back value |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final-cycle pulse |

## Verification
The bench aims at the half boundaries. If masking were applied to the loaded data instead of the address, a word load under x or y mode would return a truncated word. A half store with its halves swapped, or one that skipped the read, would overwrite the neighbouring half with stale target bits. A word store that read needlessly would show a spurious read strobe and the wrong cycle count. The bench also issues the unused opcodes and a back-to-back `start` during `busy`; a decoder that accepted either would produce an unexpected write or write-back, which the scoreboard reports.

// File: rtl/vls_pkg.sv
package vls_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_READ,
        S_MODIFY,
        S_WRITE,
        S_RECOVER,
        S_FINISH
    } vls_state_t;

    typedef enum logic [1:0] {
        MASK_SCALAR = 2'b00,
        MASK_X      = 2'b01,
        MASK_Y      = 2'b10,
        MASK_VECTOR = 2'b11
    } vls_mask_t;

    typedef enum logic [1:0] {
        K_WORD  = 2'b00,
        K_XHALF = 2'b01,
        K_YHALF = 2'b10
    } vls_kind_t;

    // 001..011 are loads, 100..110 are stores; 000 and 111 are not memory ops.
    function automatic logic op_valid(input logic [2:0] op);
        return (op != 3'b000) && (op != 3'b111);
    endfunction

    function automatic logic op_is_store(input logic [2:0] op);
        return op[2];
    endfunction

    function automatic vls_kind_t op_kind(input logic [2:0] op);
        vls_kind_t k;
        unique case (op)
            3'b010, 3'b101: k = K_XHALF;
            3'b011, 3'b110: k = K_YHALF;
            default:        k = K_WORD;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/vls_addr_mask.sv
module vls_addr_mask #(
    parameter int HALF_W = 9
) (
    input  logic [1:0]          mode,
    input  logic [2*HALF_W-1:0] alu_in,
    output logic [2*HALF_W-1:0] addr_out
);
    import vls_pkg::*;

    localparam int NHALF = 2;

    logic [NHALF-1:0] keep;

    always_comb begin
        keep[0] = (mode != MASK_Y);   // x lane survives unless y mode
        keep[1] = (mode != MASK_X);   // y lane survives unless x mode
    end

    for (genvar h = 0; h < NHALF; h++) begin : g_lane
        assign addr_out[h*HALF_W +: HALF_W] =
            keep[h] ? alu_in[h*HALF_W +: HALF_W] : '0;
    end

endmodule

// File: rtl/vls_merge.sv
module vls_merge #(
    parameter int HALF_W = 9
) (
    input  logic [1:0]          kind,
    input  logic [2*HALF_W-1:0] base,
    input  logic [2*HALF_W-1:0] patch,
    output logic [2*HALF_W-1:0] merged
);
    import vls_pkg::*;

    localparam int NHALF = 2;

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        logic take_patch;
        always_comb begin
            unique case (kind)
                K_XHALF: take_patch = (h == 0);
                K_YHALF: take_patch = (h == 1);
                default: take_patch = 1'b1;
            endcase
        end
        assign merged[h*HALF_W +: HALF_W] =
            take_patch ? patch[h*HALF_W +: HALF_W] : base[h*HALF_W +: HALF_W];
    end

endmodule

// File: rtl/vec_ldst_unit.sv
module vec_ldst_unit #(
    parameter int HALF_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [2:0]            opcode,
    input  logic [1:0]            mask_mode,
    input  logic [2*HALF_W-1:0]   alu_result,
    input  logic [2*HALF_W-1:0]   target_val,
    output logic [2*HALF_W-1:0]   mem_addr,
    output logic                  addr_oe,
    inout  wire  [2*HALF_W-1:0]   mem_data,
    output logic                  mem_rd,
    output logic                  mem_wr,
    output logic                  wb_en,
    output logic [2*HALF_W-1:0]   wb_data,
    output logic                  busy,
    output logic                  done
);
    import vls_pkg::*;

    localparam int WORD_W = 2 * HALF_W;

    vls_state_t          state, state_nx;
    logic                store_q;
    logic [1:0]          kind_q;
    logic [WORD_W-1:0]   mar_q;
    logic [WORD_W-1:0]   tgt_q;
    logic [WORD_W-1:0]   mdr_q;
    logic [WORD_W-1:0]   masked_addr;
    logic [WORD_W-1:0]   load_word;
    logic [WORD_W-1:0]   store_word;
    logic                accept;

    vls_addr_mask #(.HALF_W(HALF_W)) u_mask (
        .mode     (mask_mode),
        .alu_in   (alu_result),
        .addr_out (masked_addr)
    );

    // load: splice memory half into old target
    vls_merge #(.HALF_W(HALF_W)) u_ld_merge (
        .kind   (kind_q),
        .base   (tgt_q),
        .patch  (mdr_q),
        .merged (load_word)
    );

    // store: splice target half into word read back
    vls_merge #(.HALF_W(HALF_W)) u_st_merge (
        .kind   (kind_q),
        .base   (mdr_q),
        .patch  (tgt_q),
        .merged (store_word)
    );

    assign accept = (state == S_IDLE) && start && op_valid(opcode);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (accept) state_nx = S_ADDR;
            S_ADDR:    state_nx = (store_q && kind_q == K_WORD) ? S_WRITE : S_READ;
            S_READ:    state_nx = store_q ? S_MODIFY : S_RECOVER;
            S_MODIFY:  state_nx = S_WRITE;
            S_WRITE:   state_nx = S_RECOVER;
            S_RECOVER: state_nx = S_FINISH;
            S_FINISH:  state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            store_q <= 1'b0;
            kind_q  <= K_WORD;
            mar_q   <= '0;
            tgt_q   <= '0;
            mdr_q   <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                store_q <= op_is_store(opcode);
                kind_q  <= op_kind(opcode);
                mar_q   <= masked_addr;
                tgt_q   <= target_val;
                mdr_q   <= target_val;
            end else if (state == S_READ) begin
                mdr_q <= mem_data;
            end else if (state == S_MODIFY) begin
                mdr_q <= store_word;
            end
        end
    end

    always_comb begin
        addr_oe = 1'b0;
        mem_rd  = 1'b0;
        mem_wr  = 1'b0;
        done    = 1'b0;
        wb_en   = 1'b0;
        busy    = 1'b1;
        unique case (state)
            S_IDLE:    busy = 1'b0;
            S_ADDR:    addr_oe = 1'b1;
            S_READ:    begin addr_oe = 1'b1; mem_rd = 1'b1; end
            S_MODIFY:  addr_oe = 1'b1;
            S_WRITE:   begin addr_oe = 1'b1; mem_wr = 1'b1; end
            S_RECOVER: addr_oe = 1'b1;
            S_FINISH:  begin done = 1'b1; wb_en = !store_q; end
            default:   busy = 1'b0;
        endcase
    end

    assign wb_data  = load_word;
    assign mem_addr = addr_oe ? mar_q : 'z;
    assign mem_data = mem_wr ? mdr_q : 'z;

    // R6: strobes never overlap and never occur without a driven address
    p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));
    p_strobe_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> addr_oe);
    // R8: write-back only in the done cycle, and done lasts one cycle
    p_wb_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: an accepted start makes the unit busy next cycle
    p_busy_after_issue_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && op_valid(opcode)) |=> busy);
    // R10: address held constant for the whole instruction
    p_mar_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mar_q));

endmodule

// File: tb/vec_ldst_unit_bench.sv
`timescale 1ns/1ps
module vec_ldst_unit_bench;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   opcode = 3'b000;
    logic [1:0]   mask_mode = 2'b11;
    logic [W-1:0] alu_result = '0;
    logic [W-1:0] target_val = '0;
    logic [W-1:0] mem_addr;
    logic         addr_oe;
    wire  [W-1:0] mem_data;
    logic         mem_rd, mem_wr, wb_en, busy, done;
    logic [W-1:0] wb_data;

    int n_cmp = 0;
    int n_bad = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int done_cnt = 0;

    always #2.5 clk = ~clk;

    vec_ldst_unit u_vec_ldst_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .mask_mode(mask_mode), .alu_result(alu_result), .target_val(target_val),
        .mem_addr(mem_addr), .addr_oe(addr_oe), .mem_data(mem_data),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .wb_en(wb_en), .wb_data(wb_data),
        .busy(busy), .done(done)
    );

    // ---------------- memory model ----------------
    logic [W-1:0] mem [logic [W-1:0]];
    logic [W-1:0] rd_word = '0;

    function automatic logic [W-1:0] mem_peek(input logic [W-1:0] a);
        if (mem.exists(a)) return mem[a];
        return a ^ 18'o525252;
    endfunction

    always @(negedge clk) rd_word <= mem_peek(mem_addr);
    assign mem_data = mem_rd ? rd_word : 'z;
    always @(posedge clk) if (mem_wr) mem[mem_addr] = mem_data;

    // ---------------- checking ----------------
    task automatic check(input logic ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %o expected %o", req, what, act, exp);
        end
    endtask

    typedef struct {
        logic         is_wr;
        logic [W-1:0] addr;
        logic [W-1:0] data;
        string        req;
    } exp_t;
    exp_t sb[$];

    // monitor: pops expected items as the design produces results
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd) rd_cnt++;
            if (done) done_cnt++;
            if (mem_wr) begin
                wr_cnt++;
                if (sb.size() == 0 || !sb[0].is_wr) begin
                    check(1'b0, "R10", "unexpected write", mem_data, '0);
                end else begin
                    check(mem_addr == sb[0].addr, sb[0].req, "write address", mem_addr, sb[0].addr);
                    check(mem_data == sb[0].data, sb[0].req, "write data", mem_data, sb[0].data);
                    void'(sb.pop_front());
                end
            end
            if (wb_en) begin
                if (sb.size() == 0 || sb[0].is_wr) begin
                    check(1'b0, "R8", "unexpected write-back", wb_data, '0);
                end else begin
                    check(wb_data == sb[0].data, sb[0].req, "write-back data", wb_data, sb[0].data);
                    void'(sb.pop_front());
                end
            end
        end
    end

    function automatic logic [W-1:0] mask_addr(input logic [1:0] m, input logic [W-1:0] a);
        if (m == 2'b01) return {9'd0, a[8:0]};
        if (m == 2'b10) return {a[17:9], 9'd0};
        return a;
    endfunction

    // driver: computes expected results, issues, and checks timing
    task automatic run_op(input logic [2:0] op, input logic [1:0] m,
                          input logic [W-1:0] alu, input logic [W-1:0] tgt,
                          input string req);
        logic [W-1:0] a, old, expv;
        int exp_cyc, exp_rd, n, rd0;
        exp_t e;
        a   = mask_addr(m, alu);
        old = mem_peek(a);
        unique case (op)
            3'b001: expv = old;
            3'b010: expv = {tgt[17:9], old[8:0]};
            3'b011: expv = {old[17:9], tgt[8:0]};
            3'b100: expv = tgt;
            3'b101: expv = {old[17:9], tgt[8:0]};
            default: expv = {tgt[17:9], old[8:0]};
        endcase
        exp_cyc = (op == 3'b101 || op == 3'b110) ? 6 : 4;
        exp_rd  = (op == 3'b100) ? 0 : 1;
        e.is_wr = op[2]; e.addr = a; e.data = expv; e.req = req;
        sb.push_back(e);
        rd0 = rd_cnt;
        @(negedge clk);
        start = 1'b1; opcode = op; mask_mode = m; alu_result = alu; target_val = tgt;
        n = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            n++;
            if (!done && (mem_rd || mem_wr))
                check(mem_addr == a, "R1", "address on bus", mem_addr, a);
            if (!done) check(busy, "R7", "busy before done", busy, 1);
        end while (!done && n < 20);
        check(n == exp_cyc, "R7", "cycles to done", n, exp_cyc);
        check(!addr_oe, "R6", "address released at done", addr_oe, 0);
        check(rd_cnt - rd0 == exp_rd, op == 3'b100 ? "R4" : "R5", "read strobes",
              rd_cnt - rd0, exp_rd);
        @(negedge clk);
        check(!busy && !done, "R8", "idle after done", {busy, done}, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        check(1'b0, "WD", "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int wr0, d0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check(!busy && !done && !wb_en, "R11", "reset status", {busy, done, wb_en}, 0);
        check(!mem_rd && !mem_wr && !addr_oe, "R11", "reset bus", {mem_rd, mem_wr, addr_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1/R2: word loads under every mask
        run_op(3'b001, 2'b11, 18'o123456, 18'o0, "R2");
        run_op(3'b001, 2'b01, 18'o123456, 18'o0, "R2");
        run_op(3'b001, 2'b10, 18'o765432, 18'o0, "R2");
        run_op(3'b001, 2'b00, 18'o001777, 18'o0, "R1");
        // R3: half loads
        run_op(3'b010, 2'b11, 18'o200300, 18'o777777, "R3");
        run_op(3'b011, 2'b00, 18'o200301, 18'o777777, "R3");
        run_op(3'b010, 2'b10, 18'o444555, 18'o111222, "R3");
        // R4: word store then readback
        run_op(3'b100, 2'b11, 18'o010020, 18'o707070, "R4");
        run_op(3'b001, 2'b11, 18'o010020, 18'o0, "R4");
        // R5: half stores then readback
        run_op(3'b101, 2'b11, 18'o010020, 18'o000123, "R5");
        run_op(3'b110, 2'b01, 18'o777040, 18'o456000, "R5");
        run_op(3'b001, 2'b11, 18'o010020, 18'o0, "R5");
        run_op(3'b001, 2'b11, 18'o000040, 18'o0, "R5");

        // R9: unused opcodes are ignored
        wr0 = wr_cnt; d0 = done_cnt;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            start = 1'b1; opcode = (k == 0) ? 3'b000 : 3'b111;
            @(negedge clk);
            start = 1'b0;
            check(!busy, "R9", "busy after unused opcode", busy, 0);
            repeat (6) @(negedge clk);
        end
        check(wr_cnt == wr0 && done_cnt == d0, "R9", "no activity", done_cnt - d0, 0);

        // R10: start while busy is ignored
        wr0 = wr_cnt; d0 = done_cnt;
        begin
            exp_t e;
            e.is_wr = 1'b0; e.addr = 18'o3003;
            e.data = mem_peek(18'o003003); e.req = "R10";
            sb.push_back(e);
        end
        @(negedge clk);
        start = 1'b1; opcode = 3'b001; mask_mode = 2'b11; alu_result = 18'o003003;
        @(negedge clk);
        opcode = 3'b100; alu_result = 18'o004004; target_val = 18'o111111;
        @(negedge clk);
        start = 1'b0;
        repeat (15) @(negedge clk);
        check(done_cnt - d0 == 1, "R10", "single done", done_cnt - d0, 1);
        check(wr_cnt == wr0, "R10", "no write", wr_cnt - wr0, 0);
        check(sb.size() == 0, "R10", "scoreboard drained", sb.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule